// File: doc/BRIEF.md
# Power-Controller Command Transaction Engine

This block sits on the host side of a byte-wide link to a power-management microcontroller. It runs one whole command exchange at a time. A local requester hands over an opcode, an argument count, the argument bytes and the size of its response buffer. The engine looks up how many arguments and response bytes that opcode uses, or whether either count travels on the link as a length byte. It then moves every byte through a four-phase request/acknowledge handshake and returns the stored response bytes with a count.

The shift register on the link is modelled as a byte port. `sh_txd` with a `sh_load` strobe carries bytes out, `sh_rxd` with a `sh_rd` strobe carries bytes in, and `sh_dir_out` selects the direction. Both link control lines are active low. The acknowledge line passes through a synchroniser first. A programmable per-wait cycle limit can abort an exchange that stalls.

Top module: `pmcmd_engine`

## Requirements
- R1: After reset, `lnk_req_n` is 1, `busy`, `done` and `sh_dir_out` are 0, and `rsp_count` is 0. `lnk_req_n` stays 1 whenever `busy` is 0.
- R2: For each byte, `lnk_req_n` goes low first. It returns high only after `lnk_ack_n` has been seen low. The next byte's request starts only after `lnk_ack_n` has been seen high again.
- R3: Before the opcode byte goes out, the engine waits until `lnk_ack_n` reads 1. No request is made while the peripheral holds it at 0.
- R4: Size lookup (arguments, response; "L" means a length byte on the link):
  - 0x38 takes (0, 4).
  - 0x30 takes (4, 0).
  - 0x20 takes (L, 0).
  - 0x3A takes (2, L).
  - 0xD0 takes (0, 0).
  - An opcode without an explicit entry takes (L, L) when its bit 3 is 1 and (L, 0) otherwise; 0x0C is an example.
- R5: When the argument count is fixed and differs from `req_argc`, the exchange ends with `done` and `err` set and `rsp_count` 0. `lnk_req_n` never goes low during that exchange.
- R6: The bytes are sent in this order:
  - the opcode;
  - `req_argc` as a length byte, only when the argument count is L;
  - argument bytes 0 to `req_argc`-1, where byte i sits at `req_args[8i+7:8i]`.
- R7: When the response count is L, the first received byte gives the number of response bytes that follow. A value of 0 ends the exchange with nothing stored. Otherwise the fixed count is received.
- R8: All response bytes are clocked in. Only the first min(`req_room`, MAX_RSP) are stored, with byte i at `rsp_bytes[8i+7:8i]`, and only these are counted in `rsp_count`.
- R9: `sh_dir_out` is 1 during every transmitted byte's handshake and 0 during every received one. `sh_rd` pulses once before each receive handshake and once to capture the byte, so 2 pulses per received byte.
- R10: `busy` is 1 from acceptance until the end. `done` pulses for one cycle, with `err` and `rsp_count` valid in that cycle.
- R11: With `tmo_limit` nonzero, a wait on `lnk_ack_n` that lasts `tmo_limit` cycles ends the exchange with `err` and returns `lnk_req_n` to 1. With `tmo_limit` 0, the engine waits without limit.
- R12: A `req_argc` above MAX_ARGS is rejected as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start an exchange (taken when not busy) |
| req_opcode | input | 8 | Command opcode |
| req_argc | input | $clog2(MAX_ARGS+1) | Number of argument bytes |
| req_args | input | MAX_ARGS*8 | Argument bytes, byte i at bits 8i+7:8i |
| req_room | input | $clog2(MAX_RSP+1) | Caller response buffer size |
| tmo_limit | input | TMO_W | Wait limit in cycles, 0 disables |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Exchange rejected or aborted (valid with done) |
| rsp_count | output | $clog2(MAX_RSP+1) | Stored response bytes |
| rsp_bytes | output | MAX_RSP*8 | Stored response bytes, byte i at bits 8i+7:8i |
| lnk_req_n | output | 1 | Active-low transfer request |
| lnk_ack_n | input | 1 | Active-low transfer acknowledge |
| sh_dir_out | output | 1 | Shift direction, 1 = host sends |
| sh_load | output | 1 | Strobe: sh_txd holds a new byte |
| sh_txd | output | 8 | Byte to send |
| sh_rd | output | 1 | Strobe: receive register read |
| sh_rxd | input | 8 | Received byte |

## Verification
Two things can happen in the same cycle: the wait limit can expire just as the peripheral's acknowledge edge emerges from the synchroniser. The rule is that a seen acknowledge wins over the expiry. The bench sweeps the peripheral's acknowledge delay across the limit on a no-argument, no-response opcode. It judges that short delays complete cleanly and long delays abort with `err` and the request line high. It also checks that the outcome switches from success to error exactly once as the delay grows, with no torn exchange at the boundary.

// File: rtl/pmcmd_pkg.sv
package pmcmd_pkg;

  typedef struct packed {
    logic       arg_var;
    logic [7:0] arg_n;
    logic       rsp_var;
    logic [7:0] rsp_n;
  } size_rule_t;

  typedef enum logic [2:0] {
    S_IDLE, S_EVAL, S_WAIT, S_RXTAKE, S_STEP, S_TXLOAD, S_RXPREP, S_FIN
  } eng_state_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_OP, PH_ALEN, PH_ARG, PH_RLEN, PH_RSP
  } eng_phase_t;

  // negative count means "carried as a length byte"
  function automatic size_rule_t mk(input int a, input int r);
    size_rule_t s;
    s.arg_var = (a < 0);
    s.arg_n   = (a < 0) ? 8'd0 : 8'(a);
    s.rsp_var = (r < 0);
    s.rsp_n   = (r < 0) ? 8'd0 : 8'(r);
    return s;
  endfunction

  function automatic size_rule_t size_of(input logic [7:0] op);
    size_rule_t s;
    s = op[3] ? mk(-1, -1) : mk(-1, 0);
    case (op)
      8'h1f, 8'h21, 8'h51, 8'h82, 8'ha5, 8'hd0, 8'hef: s = mk(0, 0);
      8'h10, 8'h11, 8'h23, 8'h24, 8'h40, 8'h41, 8'h4b, 8'h4c,
      8'h50, 8'h55, 8'h57, 8'h59, 8'h70, 8'h71, 8'h72, 8'h90,
      8'ha9:                                               s = mk(1, 0);
      8'h22, 8'h52, 8'h53, 8'h60, 8'h91, 8'ha0, 8'ha1, 8'ha2,
      8'hab:                                               s = mk(2, 0);
      8'h33, 8'h56, 8'haa:                                 s = mk(3, 0);
      8'h30, 8'h3f, 8'h80, 8'ha3, 8'he1, 8'he5:            s = mk(4, 0);
      8'h31:                                               s = mk(20, 0);
      8'h18, 8'h19, 8'h48, 8'h49, 8'h58, 8'h98, 8'h99, 8'hdc,
      8'he2, 8'hea:                                        s = mk(0, 1);
      8'h5a, 8'h5b, 8'h6a:                                 s = mk(0, 2);
      8'h68, 8'h69:                                        s = mk(0, 3);
      8'h38:                                               s = mk(0, 4);
      8'h88:                                               s = mk(0, 5);
      8'h6b:                                               s = mk(0, 8);
      8'h39:                                               s = mk(0, 20);
      8'h28, 8'h29, 8'h2f, 8'h5c, 8'h6c, 8'h6d, 8'h78, 8'h79,
      8'hdd, 8'hec:                                        s = mk(0, -1);
      8'ha8, 8'hd8, 8'hd9:                                 s = mk(1, 1);
      8'h3b:                                               s = mk(2, 1);
      8'h3a:                                               s = mk(2, -1);
      8'h3c, 8'he8:                                        s = mk(3, -1);
      8'h7e, 8'h7f:                                        s = mk(4, 1);
      8'h7d:                                               s = mk(5, 1);
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pmcmd_sizes.sv
module pmcmd_sizes
  import pmcmd_pkg::*;
(
  input  logic [7:0] opcode,
  output logic       arg_var,
  output logic [7:0] arg_n,
  output logic       rsp_var,
  output logic [7:0] rsp_n
);
  size_rule_t rule;
  always_comb rule = size_of(opcode);
  assign arg_var = rule.arg_var;
  assign arg_n   = rule.arg_n;
  assign rsp_var = rule.rsp_var;
  assign rsp_n   = rule.rsp_n;
endmodule

// File: rtl/pmcmd_sync.sv
module pmcmd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  generate
    if (STAGES == 0) begin : g_pass
      assign d_out = d_in;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d_in} & {STAGES{1'b1}};
      end
      assign d_out = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pmcmd_hshake.sv
module pmcmd_hshake #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             idle_only,
  input  logic             ack_n_s,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             req_n,
  output logic             fin,
  output logic             tmo_evt,
  output logic             hs_wait
);
  typedef enum logic [1:0] {H_REST, H_IDLECHK, H_LO, H_HI} hs_state_t;
  hs_state_t        st;
  logic [TMO_W-1:0] cnt;
  logic             expire;

  // the wait ends after tmo_limit cycles without the awaited level
  assign expire  = (tmo_limit != '0) && (cnt == tmo_limit - 1'b1);
  assign hs_wait = (st != H_REST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= H_REST;
      cnt     <= '0;
      req_n   <= 1'b1;
      fin     <= 1'b0;
      tmo_evt <= 1'b0;
    end else begin
      fin     <= 1'b0;
      tmo_evt <= 1'b0;
      case (st)
        H_REST: if (start) begin
          cnt <= '0;
          if (idle_only) st <= H_IDLECHK;
          else begin
            req_n <= 1'b0;
            st    <= H_LO;
          end
        end
        H_IDLECHK: begin
          if (ack_n_s) begin
            fin <= 1'b1;
            st  <= H_REST;
          end else if (expire) begin
            tmo_evt <= 1'b1;
            st      <= H_REST;
          end else cnt <= cnt + 1'b1;
        end
        H_LO: begin
          if (!ack_n_s) begin
            req_n <= 1'b1;
            cnt   <= '0;
            st    <= H_HI;
          end else if (expire) begin
            req_n   <= 1'b1;
            tmo_evt <= 1'b1;
            st      <= H_REST;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (ack_n_s) begin
            fin <= 1'b1;
            st  <= H_REST;
          end else if (expire) begin
            tmo_evt <= 1'b1;
            st      <= H_REST;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  // R2: request returns high only after acknowledge was seen low (or on abort)
  p_req_rise_acked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_n) |-> (tmo_evt || $past(!ack_n_s)));
  // R2: a byte completes only with acknowledge seen high again
  p_fin_ack_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> $past(ack_n_s));
  // R11: completion and abort never coincide
  p_fin_xor_tmo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fin && tmo_evt));
endmodule

// File: rtl/pmcmd_engine.sv
module pmcmd_engine
  import pmcmd_pkg::*;
#(
  parameter int MAX_ARGS    = 8,
  parameter int MAX_RSP     = 8,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW  = $clog2(MAX_ARGS + 1),
  localparam int RW  = $clog2(MAX_RSP + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [7:0]            req_opcode,
  input  logic [AW-1:0]         req_argc,
  input  logic [MAX_ARGS*8-1:0] req_args,
  input  logic [RW-1:0]         req_room,
  input  logic [TMO_W-1:0]      tmo_limit,
  output logic                  busy,
  output logic                  done,
  output logic                  err,
  output logic [RW-1:0]         rsp_count,
  output logic [MAX_RSP*8-1:0]  rsp_bytes,
  output logic                  lnk_req_n,
  input  logic                  lnk_ack_n,
  output logic                  sh_dir_out,
  output logic                  sh_load,
  output logic [7:0]            sh_txd,
  output logic                  sh_rd,
  input  logic [7:0]            sh_rxd
);
  localparam int AIW = (MAX_ARGS > 1) ? $clog2(MAX_ARGS) : 1;
  localparam int RIW = (MAX_RSP > 1) ? $clog2(MAX_RSP) : 1;

  eng_state_t                 st;
  eng_phase_t                 phase;
  logic [7:0]                 op_q;
  logic [AW-1:0]              argc_q;
  logic [MAX_ARGS-1:0][7:0]   args_q;
  logic [RW-1:0]              room_q;
  logic [MAX_RSP-1:0][7:0]    rsp_q;
  logic [7:0]                 idx;
  logic [7:0]                 total;
  logic [7:0]                 rx_q;
  logic                       err_q;

  logic       arg_var, rsp_var;
  logic [7:0] arg_n, rsp_n;
  logic       ack_s;
  logic       hs_start, hs_idle_only, hs_fin, hs_tmo, hs_wait;
  logic       bad_req, to_rx, is_rx_phase;
  logic [7:0] tx_byte;

  pmcmd_sizes u_sizes (
    .opcode (op_q),
    .arg_var(arg_var),
    .arg_n  (arg_n),
    .rsp_var(rsp_var),
    .rsp_n  (rsp_n)
  );

  pmcmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (lnk_ack_n),
    .d_out(ack_s)
  );

  pmcmd_hshake #(.TMO_W(TMO_W)) u_hs (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (hs_start),
    .idle_only(hs_idle_only),
    .ack_n_s  (ack_s),
    .tmo_limit(tmo_limit),
    .req_n    (lnk_req_n),
    .fin      (hs_fin),
    .tmo_evt  (hs_tmo),
    .hs_wait  (hs_wait)
  );

  // named internal events
  assign bad_req = (argc_q > AW'(MAX_ARGS)) ||
                   (!arg_var && (8'(argc_q) != arg_n));
  assign to_rx   = ((phase == PH_OP)   && !arg_var && (argc_q == '0)) ||
                   ((phase == PH_ALEN) && (argc_q == '0)) ||
                   ((phase == PH_ARG)  && ((9'(idx) + 9'd1) >= 9'(argc_q)));
  assign is_rx_phase  = (phase == PH_RLEN) || (phase == PH_RSP);
  assign hs_idle_only = (st == S_EVAL);
  assign hs_start     = ((st == S_EVAL) && !bad_req) ||
                        (st == S_TXLOAD) || (st == S_RXPREP);

  always_comb begin
    case (phase)
      PH_OP:   tx_byte = op_q;
      PH_ALEN: tx_byte = 8'(argc_q);
      default: tx_byte = args_q[idx[AIW-1:0]];
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign err       = err_q;
  assign sh_rd     = (st == S_RXPREP) || (st == S_RXTAKE);
  assign rsp_bytes = rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      phase      <= PH_IDLE;
      op_q       <= '0;
      argc_q     <= '0;
      args_q     <= '0;
      room_q     <= '0;
      rsp_q      <= '0;
      rsp_count  <= '0;
      idx        <= '0;
      total      <= '0;
      rx_q       <= '0;
      err_q      <= 1'b0;
      sh_dir_out <= 1'b0;
      sh_load    <= 1'b0;
      sh_txd     <= '0;
    end else begin
      sh_load <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q      <= req_opcode;
          argc_q    <= req_argc;
          args_q    <= req_args;
          room_q    <= (req_room > RW'(MAX_RSP)) ? RW'(MAX_RSP) : req_room;
          rsp_q     <= '0;
          rsp_count <= '0;
          err_q     <= 1'b0;
          idx       <= '0;
          st        <= S_EVAL;
        end
        S_EVAL: begin
          phase <= PH_IDLE;
          if (bad_req) begin
            err_q <= 1'b1;
            st    <= S_FIN;
          end else st <= S_WAIT;
        end
        S_WAIT: begin
          if (hs_tmo) begin
            err_q <= 1'b1;
            st    <= S_FIN;
          end else if (hs_fin) st <= is_rx_phase ? S_RXTAKE : S_STEP;
        end
        S_TXLOAD: begin
          sh_dir_out <= 1'b1;
          sh_txd     <= tx_byte;
          sh_load    <= 1'b1;
          st         <= S_WAIT;
        end
        S_RXPREP: begin
          sh_dir_out <= 1'b0;
          st         <= S_WAIT;
        end
        S_RXTAKE: begin
          rx_q <= sh_rxd;
          if ((phase == PH_RSP) && (idx < 8'(room_q))) begin
            rsp_q[idx[RIW-1:0]] <= sh_rxd;
            rsp_count           <= rsp_count + 1'b1;
          end
          st <= S_STEP;
        end
        S_STEP: begin
          case (phase)
            PH_IDLE: begin
              phase <= PH_OP;
              st    <= S_TXLOAD;
            end
            PH_OP: if (arg_var) begin
              phase <= PH_ALEN;
              st    <= S_TXLOAD;
            end else if (argc_q != '0) begin
              phase <= PH_ARG;
              idx   <= '0;
              st    <= S_TXLOAD;
            end
            PH_ALEN: if (argc_q != '0) begin
              phase <= PH_ARG;
              idx   <= '0;
              st    <= S_TXLOAD;
            end
            PH_ARG: if (!to_rx) begin
              idx <= idx + 1'b1;
              st  <= S_TXLOAD;
            end
            PH_RLEN: begin
              if (rx_q == '0) st <= S_FIN;
              else begin
                total <= rx_q;
                phase <= PH_RSP;
                idx   <= '0;
                st    <= S_RXPREP;
              end
            end
            default: begin
              if ((9'(idx) + 9'd1) < 9'(total)) begin
                idx <= idx + 1'b1;
                st  <= S_RXPREP;
              end else st <= S_FIN;
            end
          endcase
          if (to_rx) begin
            idx <= '0;
            if (rsp_var) begin
              phase <= PH_RLEN;
              st    <= S_RXPREP;
            end else if (rsp_n == '0) st <= S_FIN;
            else begin
              total <= rsp_n;
              phase <= PH_RSP;
              st    <= S_RXPREP;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: request line quiet while idle
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> lnk_req_n);
  // R10: completion is a single-cycle pulse
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: never more stored bytes than room
  p_count_fits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rsp_count <= room_q));
  // R9: receive handshake is preceded by a register read
  p_preread_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lnk_req_n) && !sh_dir_out) |-> $past(sh_rd));
  // R9: transmit byte stays put while the request is low
  p_txd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lnk_req_n && $past(!lnk_req_n) && sh_dir_out) |-> $stable(sh_txd));
  // R5: a rejected exchange never starts a handshake
  p_reject_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EVAL && bad_req) |=> (lnk_req_n && !hs_wait));
endmodule

// File: tb/test_pmcmd_engine.sv
module test_pmcmd_engine;
  localparam int MAX_ARGS = 8;
  localparam int MAX_RSP  = 8;
  localparam int TMO_W    = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_opcode = '0;
  logic [3:0]  req_argc = '0;
  logic [63:0] req_args = '0;
  logic [3:0]  req_room = '0;
  logic [15:0] tmo_limit = '0;
  logic        busy, done, err, lnk_req_n, sh_dir_out, sh_load, sh_rd;
  logic [3:0]  rsp_count;
  logic [63:0] rsp_bytes;
  logic [7:0]  sh_txd;
  logic [7:0]  sh_rxd = '0;
  logic        pf_ack_n = 1'b1;
  logic        pf_busy = 1'b0;
  logic        pf_stuck = 1'b0;
  logic        lnk_ack_n;
  int          pf_lo_dly = 2;
  int          pf_hi_dly = 2;

  int n_chk = 0, n_err = 0;
  logic [7:0] tx_log [64];
  logic [7:0] rx_src [64];
  int tx_n = 0, rx_k = 0, rd_cnt = 0, r2_bad = 0, req_falls = 0;
  logic        d_err;
  logic [3:0]  d_cnt;
  logic [63:0] d_data;
  bit          got;

  assign lnk_ack_n = pf_ack_n & ~pf_busy;

  always #2 clk = ~clk;

  pmcmd_engine #(.MAX_ARGS(MAX_ARGS), .MAX_RSP(MAX_RSP), .TMO_W(TMO_W)) i_pmcmd_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_argc(req_argc), .req_args(req_args), .req_room(req_room),
    .tmo_limit(tmo_limit), .busy(busy), .done(done), .err(err),
    .rsp_count(rsp_count), .rsp_bytes(rsp_bytes), .lnk_req_n(lnk_req_n),
    .lnk_ack_n(lnk_ack_n), .sh_dir_out(sh_dir_out), .sh_load(sh_load),
    .sh_txd(sh_txd), .sh_rd(sh_rd), .sh_rxd(sh_rxd)
  );

  // peripheral model
  initial begin
    forever begin
      @(negedge lnk_req_n);
      wait (!pf_stuck);
      repeat (pf_lo_dly) @(posedge clk);
      #1;
      if (!lnk_req_n) begin
        if (sh_dir_out) begin
          if (tx_n < 64) tx_log[tx_n] = sh_txd;
          tx_n++;
        end else begin
          sh_rxd = rx_src[rx_k % 64];
          rx_k++;
        end
        pf_ack_n = 1'b0;
        @(posedge lnk_req_n);
        repeat (pf_hi_dly) @(posedge clk);
        #1;
        pf_ack_n = 1'b1;
      end
    end
  end

  // R2 monitors
  always @(posedge lnk_req_n) if (rst_n && lnk_ack_n) r2_bad++;
  always @(negedge lnk_req_n) begin
    if (rst_n) begin
      req_falls++;
      if (!lnk_ack_n) r2_bad++;
    end
  end
  always @(negedge clk) if (rst_n && sh_rd) rd_cnt++;

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    tx_n = 0; rx_k = 0; rd_cnt = 0; r2_bad = 0; req_falls = 0;
  endtask

  task automatic issue(input logic [7:0] op, input int argc, input int room,
                       input logic [63:0] args);
    @(negedge clk);
    req_opcode = op; req_argc = 4'(argc); req_room = 4'(room);
    req_args = args; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int cap);
    got = 0;
    for (int c = 0; c < cap; c++) begin
      if (done) begin
        got = 1; d_err = err; d_cnt = rsp_count; d_data = rsp_bytes;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic run(input logic [7:0] op, input int argc, input int room,
                     input logic [63:0] args);
    issue(op, argc, room, args);
    wait_done(2000);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 req_n", 64'(lnk_req_n), 64'd1);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 dir", 64'(sh_dir_out), 64'd0);
    chk("R1 count", 64'(rsp_count), 64'd0);
  endtask

  task automatic t_fixed_read();
    clr();
    rx_src[0] = 8'h11; rx_src[1] = 8'h22; rx_src[2] = 8'h33; rx_src[3] = 8'h44;
    run(8'h38, 0, 4, 64'h0);
    chk("R10 done seen", 64'(got), 64'd1);
    chk("R10 err", 64'(d_err), 64'd0);
    chk("R4 count", 64'(d_cnt), 64'd4);
    chk("R8 data", d_data[31:0], 64'h44332211);
    chk("R6 tx bytes", 64'(tx_n), 64'd1);
    chk("R6 opcode", 64'(tx_log[0]), 64'h38);
    chk("R9 rx handshakes", 64'(rx_k), 64'd4);
    chk("R9 sh_rd pulses", 64'(rd_cnt), 64'd8);
    chk("R2 order", 64'(r2_bad), 64'd0);
  endtask

  task automatic t_fixed_write();
    clr();
    run(8'h30, 4, 0, 64'hd4c3b2a1);
    chk("R5 err", 64'(d_err), 64'd0);
    chk("R6 tx n", 64'(tx_n), 64'd5);
    chk("R6 seq", {24'h0, tx_log[0], tx_log[1], tx_log[2], tx_log[3], tx_log[4]},
        64'h30a1b2c3d4);
    chk("R4 no rx", 64'(rx_k), 64'd0);
    chk("R10 count", 64'(d_cnt), 64'd0);
  endtask

  task automatic t_var_args();
    clr();
    run(8'h20, 3, 0, 64'h00776655);
    chk("R6 tx n", 64'(tx_n), 64'd5);
    chk("R6 seq", {24'h0, tx_log[0], tx_log[1], tx_log[2], tx_log[3], tx_log[4]},
        64'h2003556677);
    chk("R4 var args err", 64'(d_err), 64'd0);
  endtask

  task automatic t_var_rsp();
    clr();
    rx_src[0] = 8'd3; rx_src[1] = 8'hab; rx_src[2] = 8'hcd; rx_src[3] = 8'hef;
    run(8'h3a, 2, 8, 64'h0000beef);
    chk("R6 seq", {40'h0, tx_log[0], tx_log[1], tx_log[2]}, 64'h3aefbe);
    chk("R7 count", 64'(d_cnt), 64'd3);
    chk("R7 data", d_data[23:0], 64'hefcdab);
    chk("R7 rx used", 64'(rx_k), 64'd4);
    clr();
    rx_src[0] = 8'd0;
    run(8'h0c, 1, 8, 64'h5a);
    chk("R4 default seq", {40'h0, tx_log[0], tx_log[1], tx_log[2]}, 64'h0c015a);
    chk("R7 zero len count", 64'(d_cnt), 64'd0);
    chk("R7 zero len rx", 64'(rx_k), 64'd1);
    chk("R7 zero len err", 64'(d_err), 64'd0);
  endtask

  task automatic t_overflow();
    clr();
    rx_src[0] = 8'h91; rx_src[1] = 8'h92; rx_src[2] = 8'h93; rx_src[3] = 8'h94;
    run(8'h38, 0, 2, 64'h0);
    chk("R8 all clocked", 64'(rx_k), 64'd4);
    chk("R8 count", 64'(d_cnt), 64'd2);
    chk("R8 data", d_data, 64'h9291);
  endtask

  task automatic t_reject();
    clr();
    run(8'h30, 2, 0, 64'h1234);
    chk("R5 done", 64'(got), 64'd1);
    chk("R5 err", 64'(d_err), 64'd1);
    chk("R5 count", 64'(d_cnt), 64'd0);
    chk("R5 no request", 64'(req_falls), 64'd0);
    clr();
    run(8'h20, 9, 0, 64'h0);
    chk("R12 err", 64'(d_err), 64'd1);
    chk("R12 no request", 64'(req_falls), 64'd0);
  endtask

  task automatic t_idle_wait();
    clr();
    pf_busy = 1'b1;
    issue(8'hd0, 0, 0, 64'h0);
    repeat (50) @(negedge clk);
    chk("R3 held off", 64'(req_falls), 64'd0);
    chk("R10 busy while held", 64'(busy), 64'd1);
    pf_busy = 1'b0;
    wait_done(2000);
    chk("R3 proceeds", 64'(got), 64'd1);
    chk("R3 opcode", 64'(tx_log[0]), 64'hd0);
    chk("R3 err", 64'(d_err), 64'd0);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_timeout();
    clr();
    tmo_limit = 16'd20;
    pf_stuck = 1'b1;
    issue(8'hd0, 0, 0, 64'h0);
    wait_done(200);
    chk("R11 abort done", 64'(got), 64'd1);
    chk("R11 abort err", 64'(d_err), 64'd1);
    @(negedge clk);
    chk("R11 req released", 64'(lnk_req_n), 64'd1);
    pf_stuck = 1'b0;
    repeat (10) @(negedge clk);
    clr();
    tmo_limit = 16'd0;
    pf_stuck = 1'b1;
    issue(8'hd0, 0, 0, 64'h0);
    wait_done(500);
    chk("R11 no limit waits", 64'(got), 64'd0);
    pf_stuck = 1'b0;
    wait_done(2000);
    chk("R11 no limit completes", 64'(got), 64'd1);
    chk("R11 no limit err", 64'(d_err), 64'd0);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_race_sweep();
    bit seen_err = 0;
    bit mono = 1;
    bit first_err = 0, last_err = 0;
    tmo_limit = 16'd8;
    for (int d = 1; d <= 16; d++) begin
      clr();
      pf_lo_dly = d;
      run(8'hd0, 0, 0, 64'h0);
      if (d_err) seen_err = 1;
      else if (seen_err) mono = 0;
      if (d == 1) first_err = d_err;
      if (d == 16) last_err = d_err;
      if (d_err) chk("R11 sweep req high", 64'(lnk_req_n), 64'd1);
      else chk("R2 sweep order", 64'(r2_bad), 64'd0);
      repeat (30) @(negedge clk);
    end
    chk("R11 sweep short ok", 64'(first_err), 64'd0);
    chk("R11 sweep long err", 64'(last_err), 64'd1);
    chk("R11 sweep monotonic", 64'(mono), 64'd1);
    pf_lo_dly = 2;
    tmo_limit = 16'd0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed_read();
    t_fixed_write();
    t_var_args();
    t_var_rsp();
    t_overflow();
    t_reject();
    t_idle_wait();
    t_timeout();
    t_race_sweep();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule